// File: doc/BRIEF.md
# 8x8 Row-Column DCT Engine

The block computes the two-dimensional 8x8 forward DCT of a block of signed samples. Samples arrive one per handshake in row-major order. They are stored in one of two input banks. A single two-lane 8-point DCT unit transforms a pair of rows per step. Four steps finish the row pass, and the results go into an 8x8 transpose store at 32-bit signed precision.

The same unit then runs again on pairs of columns of that store, which gives the column pass. Each result is written back into the slot it was read from. The store then already holds the coefficients in the final orientation, and they stream out as 64 consecutive beats in row-major order, with a last flag on the final beat.

Because the input banks alternate, the next block can be loaded while the current one is in its column pass or being emitted.

Top module: `rc_dct8x8`

## Requirements
- R1: A sample is taken on a rising clock edge where `in_valid_i` and `in_ready_o` are both high. The k-th accepted sample of a block (k = 0..63) is element row k/8, column k%8. Idle cycles between samples have no effect on the result.
- R2: After reset `in_ready_o` is high. It is low exactly while the input bank due to receive the next sample still holds a block whose row pass has not finished. No stored block is overwritten or lost.
- R3: 1D transform: y[k] = floor((sum over n of C[k][n]*x[n]) / 2^11), wrapped to 32-bit signed. Here C[0][n] = 724 and C[k][n] = round(1024*cos((2n+1)*k*pi/16)) for k = 1..7. The row pass applies this to each input row, giving R[r][k]. The column pass applies it to each column of R, giving Y[k][c].
- R4: Row-pass results are held as 32-bit signed values, so full-scale 16-bit inputs (including -32768 and 32767) produce exact results.
- R5: Y is emitted on `out_data_o` as 64 consecutive valid beats, Y[k][c] on beat 8k+c. `out_last_o` is high only on beat 63.
- R6: Each pass takes four steps. When the engine is idle, the first coefficient is valid 9 clock cycles after the edge that accepted sample 63.
- R7: Blocks leave in the order they arrived. This holds for back-to-back input, which eventually stalls the input.
- R8: While `rst_ni` is low, `out_valid_o` and `out_last_o` are low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Input sample can be accepted |
| in_data_i | input | SAMPLE_W | Signed input sample, row-major |
| out_valid_o | output | 1 | Output coefficient valid |
| out_last_o | output | 1 | Final coefficient of a block |
| out_data_o | output | MID_W | Signed coefficient, row-major |

## Verification
The bench builds the engine with its defaults: 16-bit samples and 32-bit intermediate precision. This lets full-scale patterns, constant extremes and alternating sign checkerboards drive the largest row-pass and column-pass sums, and every result is compared against a direct matrix-product model.

Ten blocks sent back to back outrun the 73-cycle engine period, so the input stall path and bank reuse are exercised. An idle start exposes the exact four-step-per-pass latency.

// File: rtl/rc_dct_pkg.sv
package rc_dct_pkg;
  localparam int N         = 8;
  localparam int STEPS     = N / 2;
  localparam int COEF_FRAC = 10;
  localparam int COEF_W    = COEF_FRAC + 2;
  localparam int SHIFT     = COEF_FRAC + 1;
  localparam int ADDR_W    = $clog2(N * N);
  localparam int STEP_CW   = $clog2(STEPS + 1);
  localparam int STEP_IW   = $clog2(STEPS);

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL, ST_EMIT} eng_state_e;

  // cos(i*pi/16) scaled by 2^COEF_FRAC, i = 0..8
  function automatic int cos_base(input int i);
    case (i)
      0: return 1024;
      1: return 1004;
      2: return 946;
      3: return 851;
      4: return 724;
      5: return 569;
      6: return 392;
      7: return 200;
      default: return 0;
    endcase
  endfunction

  function automatic int coef(input int k, input int n);
    int m;
    if (k == 0) return cos_base(4);
    m = ((2 * n + 1) * k) % 32;
    if (m <= 8)       return cos_base(m);
    else if (m <= 16) return -cos_base(16 - m);
    else if (m <= 24) return -cos_base(m - 16);
    else              return cos_base(32 - m);
  endfunction
endpackage

// File: rtl/dct8_lane.sv
module dct8_lane
  import rc_dct_pkg::*;
#(
  parameter int W     = 32,
  parameter int ACC_W = W + COEF_W + 3
) (
  input  logic signed [W-1:0] x_i [N],
  output logic signed [W-1:0] y_o [N]
);
  localparam int HALF = N / 2;

  logic signed [ACC_W-1:0] sum_q [HALF];
  logic signed [ACC_W-1:0] dif_q [HALF];
  logic signed [ACC_W-1:0] acc;

  // fold: even outputs use sums, odd outputs use differences
  always_comb begin
    for (int n = 0; n < HALF; n++) begin
      sum_q[n] = ACC_W'(x_i[n]) + ACC_W'(x_i[N-1-n]);
      dif_q[n] = ACC_W'(x_i[n]) - ACC_W'(x_i[N-1-n]);
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < N; k++) begin
      acc = '0;
      for (int n = 0; n < HALF; n++) begin
        if (k % 2 == 0) acc = acc + sum_q[n] * ACC_W'(coef(k, n));
        else            acc = acc + dif_q[n] * ACC_W'(coef(k, n));
      end
      y_o[k] = W'(acc >>> SHIFT);
    end
  end
endmodule

// File: rtl/dct_in_pingpong.sv
module dct_in_pingpong
  import rc_dct_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int MID_W    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  input  logic [SAMPLE_W-1:0]        in_data_i,
  output logic                       in_ready_o,
  input  logic                       rd_bank_i,
  input  logic [STEP_IW-1:0]         row_sel_i,
  input  logic                       release_i,
  output logic                       has_block_o,
  output logic signed [MID_W-1:0]    rows_o [2][N]
);
  localparam int DEPTH = N * N;

  logic signed [SAMPLE_W-1:0] mem [2][DEPTH];
  logic [ADDR_W-1:0] wr_cnt_q;
  logic              wr_bank_q;
  logic [1:0]        full_q, full_d;
  logic              accept, blk_done;

  assign in_ready_o  = !full_q[wr_bank_q];
  assign accept      = in_valid_i && in_ready_o;
  assign blk_done    = accept && (wr_cnt_q == ADDR_W'(DEPTH - 1));
  assign has_block_o = full_q[rd_bank_i];

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_bank_q][wr_cnt_q] <= signed'(in_data_i);
  end

  always_comb begin
    full_d = full_q;
    if (release_i) full_d[rd_bank_i] = 1'b0;
    if (blk_done)  full_d[wr_bank_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q  <= '0;
      wr_bank_q <= 1'b0;
      full_q    <= '0;
    end else begin
      full_q <= full_d;
      if (accept) begin
        wr_cnt_q <= wr_cnt_q + 1'b1;
        if (blk_done) wr_bank_q <= ~wr_bank_q;
      end
    end
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      for (int j = 0; j < N; j++) begin
        rows_o[l][j] = MID_W'(mem[rd_bank_i][ADDR_W'((2 * int'(row_sel_i) + l) * N + j)]);
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank_chk
    AST_FULL_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_q[b] && !(release_i && rd_bank_i == b)) |=> full_q[b]); // R2
  end
  AST_RELEASE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |-> full_q[rd_bank_i]); // R2
endmodule

// File: rtl/dct_tpose_buf.sv
module dct_tpose_buf
  import rc_dct_pkg::*;
#(
  parameter int MID_W = 32
) (
  input  logic                    clk_i,
  input  logic                    col_mode_i,
  input  logic [STEP_IW-1:0]      sel_i,
  input  logic                    wr_en_i,
  input  logic signed [MID_W-1:0] wr_data_i [2][N],
  output logic signed [MID_W-1:0] rd_data_o [2][N],
  input  logic [ADDR_W-1:0]       emit_idx_i,
  output logic signed [MID_W-1:0] emit_data_o
);
  localparam int DEPTH = N * N;

  logic signed [MID_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]       addr [2][N];

  // line l of the current step, element j; column mode walks down a column
  always_comb begin
    for (int l = 0; l < 2; l++) begin
      for (int j = 0; j < N; j++) begin
        if (col_mode_i) addr[l][j] = ADDR_W'(j * N + 2 * int'(sel_i) + l);
        else            addr[l][j] = ADDR_W'((2 * int'(sel_i) + l) * N + j);
        rd_data_o[l][j] = mem[addr[l][j]];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < 2; l++) begin
        for (int j = 0; j < N; j++) mem[addr[l][j]] <= wr_data_i[l][j];
      end
    end
  end

  assign emit_data_o = mem[emit_idx_i];
endmodule

// File: rtl/rc_dct8x8.sv
module rc_dct8x8
  import rc_dct_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int MID_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_data_i,
  output logic                out_valid_o,
  output logic                out_last_o,
  output logic [MID_W-1:0]    out_data_o
);
  localparam int LAST_IDX = N * N - 1;

  eng_state_e           state_q;
  logic [STEP_CW-1:0]   step_cnt_q;
  logic [STEP_IW-1:0]   step_idx;
  logic                 rd_bank_q;
  logic [ADDR_W-1:0]    emit_idx_q;
  logic                 has_block, release_bank, step_last, run_step;

  logic signed [MID_W-1:0] in_rows  [2][N];
  logic signed [MID_W-1:0] mid_rows [2][N];
  logic signed [MID_W-1:0] lane_in  [2][N];
  logic signed [MID_W-1:0] lane_out [2][N];
  logic signed [MID_W-1:0] emit_data;

  assign step_idx     = STEP_IW'(STEPS - int'(step_cnt_q));
  assign step_last    = (step_cnt_q == STEP_CW'(1));
  assign run_step     = (state_q == ST_ROW) || (state_q == ST_COL);
  assign release_bank = (state_q == ST_ROW) && step_last;

  dct_in_pingpong #(.SAMPLE_W(SAMPLE_W), .MID_W(MID_W)) u_in (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_ready_o  (in_ready_o),
    .rd_bank_i   (rd_bank_q),
    .row_sel_i   (step_idx),
    .release_i   (release_bank),
    .has_block_o (has_block),
    .rows_o      (in_rows)
  );

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      for (int j = 0; j < N; j++) begin
        lane_in[l][j] = (state_q == ST_COL) ? mid_rows[l][j] : in_rows[l][j];
      end
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    dct8_lane #(.W(MID_W)) u_lane (
      .x_i (lane_in[l]),
      .y_o (lane_out[l])
    );
  end

  dct_tpose_buf #(.MID_W(MID_W)) u_tbuf (
    .clk_i       (clk_i),
    .col_mode_i  (state_q == ST_COL),
    .sel_i       (step_idx),
    .wr_en_i     (run_step),
    .wr_data_i   (lane_out),
    .rd_data_o   (mid_rows),
    .emit_idx_i  (emit_idx_q),
    .emit_data_o (emit_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_cnt_q <= '0;
      rd_bank_q  <= 1'b0;
      emit_idx_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (has_block) begin
          state_q    <= ST_ROW;
          step_cnt_q <= STEP_CW'(STEPS);
        end
        ST_ROW: begin
          step_cnt_q <= step_cnt_q - 1'b1;
          if (step_last) begin
            state_q    <= ST_COL;
            step_cnt_q <= STEP_CW'(STEPS);
            rd_bank_q  <= ~rd_bank_q;
          end
        end
        ST_COL: begin
          step_cnt_q <= step_cnt_q - 1'b1;
          if (step_last) begin
            state_q    <= ST_EMIT;
            emit_idx_q <= '0;
          end
        end
        default: begin
          emit_idx_q <= emit_idx_q + 1'b1;
          if (emit_idx_q == ADDR_W'(LAST_IDX)) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign out_valid_o = (state_q == ST_EMIT);
  assign out_last_o  = (state_q == ST_EMIT) && (emit_idx_q == ADDR_W'(LAST_IDX));
  assign out_data_o  = emit_data;

  AST_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_step |-> (step_cnt_q >= STEP_CW'(1) && step_cnt_q <= STEP_CW'(STEPS))); // R6
  AST_ROW_TO_COL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ROW && step_last) |=> (state_q == ST_COL && step_cnt_q == STEP_CW'(STEPS))); // R6
  AST_ROW_HAS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ROW) |-> has_block); // R2
  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o); // R5
  AST_EMIT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_last_o) |=> out_valid_o); // R5
endmodule

// File: tb/rc_dct8x8_tb.sv
module rc_dct8x8_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid, out_last;
  logic [31:0] out_data;

  int     checks = 0;
  int     errors = 0;
  int     cyc = 0;
  bit     run = 0;
  bit     done = 0;
  bit     stall_seen = 0;
  bit     lat_arm = 0;
  int     last_acc_cyc = 0;
  int     beat_idx = 0;
  int     blocks_out = 0;
  int     rnd_state = 32'h1ace_b00c;
  string  cur_tag = "R3";
  int     cmat [8][8];
  longint exp_q [$];

  always #4 clk = ~clk;

  rc_dct8x8 u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .out_valid_o(out_valid), .out_last_o(out_last), .out_data_o(out_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int rnd();
    rnd_state ^= rnd_state << 13;
    rnd_state ^= rnd_state >>> 17;
    rnd_state ^= rnd_state << 5;
    return rnd_state & 32'h7fff_ffff;
  endfunction

  // direct matrix-product model of R3
  function automatic void push_expected(input int blk[64]);
    longint r [8][8];
    longint s;
    for (int row = 0; row < 8; row++)
      for (int k = 0; k < 8; k++) begin
        s = 0;
        for (int n = 0; n < 8; n++) s += longint'(cmat[k][n]) * blk[row*8+n];
        r[row][k] = longint'(int'(s >>> 11));
      end
    for (int k = 0; k < 8; k++)
      for (int c = 0; c < 8; c++) begin
        s = 0;
        for (int rr = 0; rr < 8; rr++) s += longint'(cmat[k][rr]) * r[rr][c];
        exp_q.push_back(longint'(int'(s >>> 11)));
      end
  endfunction

  task automatic send_block(input int blk[64], input bit gaps);
    int i = 0;
    push_expected(blk);
    while (i < 64) begin
      @(negedge clk);
      if (gaps && (rnd() % 3 == 0)) in_valid = 1'b0;
      else begin
        in_valid = 1'b1;
        in_data  = 16'(blk[i]);
        if (in_ready) begin
          if (i == 63) last_acc_cyc = cyc + 1;
          i++;
        end else stall_seen = 1;
      end
    end
  endtask

  task automatic idle_input();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run) begin
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R7 unexpected beat", longint'(out_data), 0);
        else begin
          longint e;
          e = exp_q.pop_front();
          check(longint'(signed'(out_data)) == e, cur_tag, longint'(signed'(out_data)), e);
          check(out_last == (beat_idx == 63), "R5 last", longint'(out_last), longint'(beat_idx == 63));
          if (beat_idx == 0 && lat_arm) begin
            check(cyc == last_acc_cyc + 9, "R6 latency", cyc - last_acc_cyc, 9);
            lat_arm = 0;
          end
        end
        beat_idx = (beat_idx + 1) % 64;
        if (beat_idx == 0) blocks_out++;
      end else begin
        if (beat_idx != 0) check(0, "R5 gap in block", beat_idx, 64);
        if (out_last) check(0, "R5 last without valid", 1, 0);
      end
    end
  end

  initial begin
    int blk [64];
    int b0;
    for (int k = 0; k < 8; k++)
      for (int n = 0; n < 8; n++) begin
        real v;
        v = 1024.0 * $cos((2.0 * n + 1.0) * k * 3.14159265358979 / 16.0);
        if (k == 0) cmat[k][n] = 724;
        else cmat[k][n] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
      end

    // R8: reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R8 ready", longint'(in_ready), 1);
    check(out_valid == 1'b0, "R8 valid", longint'(out_valid), 0);
    check(out_last == 1'b0, "R8 last", longint'(out_last), 0);
    rst_ni = 1'b1;
    run = 1;
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready after reset", longint'(in_ready), 1);

    // R3/R6: ramp, engine idle
    for (int i = 0; i < 64; i++) blk[i] = (i % 8) * 30 - (i / 8) * 17 + 5;
    cur_tag = "R3 ramp";
    lat_arm = 1;
    send_block(blk, 0);
    idle_input();
    wait_drain();
    check(lat_arm == 0, "R6 latency observed", longint'(lat_arm), 0);

    // R1: gapped input, random data
    for (int i = 0; i < 64; i++) blk[i] = (rnd() % 4096) - 2048;
    cur_tag = "R1 gapped";
    b0 = blocks_out;
    lat_arm = 1;
    send_block(blk, 1);
    idle_input();
    wait_drain();
    check(blocks_out == b0 + 1, "R1 block count", blocks_out - b0, 1);

    // R4: full-scale extremes
    cur_tag = "R4 extreme";
    for (int i = 0; i < 64; i++) blk[i] = 32767;
    send_block(blk, 0);
    for (int i = 0; i < 64; i++) blk[i] = -32768;
    send_block(blk, 0);
    for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2 == 0) ? 32767 : -32768;
    send_block(blk, 0);
    for (int i = 0; i < 64; i++) blk[i] = ((i % 8) < 4) ? -32768 : 32767;
    send_block(blk, 0);
    idle_input();
    wait_drain();

    // R7/R2: ten back-to-back blocks force an input stall
    cur_tag = "R7 stream";
    stall_seen = 0;
    b0 = blocks_out;
    for (int b = 0; b < 10; b++) begin
      for (int i = 0; i < 64; i++) blk[i] = (rnd() % 65536) - 32768;
      send_block(blk, 0);
    end
    idle_input();
    wait_drain();
    check(stall_seen == 1, "R2 stall seen", longint'(stall_seen), 1);
    check(blocks_out == b0 + 10, "R7 blocks out", blocks_out - b0, 10);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R7 queue empty", exp_q.size(), 0);
    check(out_valid == 1'b0, "R5 idle after stream", longint'(out_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule